// File: doc/BRIEF.md
# Trace ID filter control unit

This block sits between one shared trace stream and two trace buffer sinks. Each sink has its own allow-list, a bitmap with one bit for every possible trace ID. An incoming beat is offered to a sink only when that sink's bit for the beat's ID is set. A beat that no sink wants is consumed at once and discarded.

Software fills the bitmaps through an APB-style register port. Bitmap writes take effect only while the unit is unlocked. A dedicated key unlocks the unit, and any other value written to the same register locks it again. The bitmaps can be read back at any time.

The trace side uses valid/ready handshakes. The input stalls only on a sink that wants the beat and is not ready. A beat wanted by both sinks is offered to both in the same cycle. It retires only after both have taken it, and neither sink sees it twice.

Top module: `trace_id_filter`

## Requirements
- R1: After reset the unit is locked (the status register at 0xFB4 reads 0x2), every bitmap register reads zero, and every beat is dropped: no sink valid, and the input is ready.
- R2: Writing 0xC5ACCE55 to 0xFB0 unlocks the unit, so the status at 0xFB4 reads 0x0. Writing any other value to 0xFB0 locks it, so the status reads 0x2 (bit 1 = locked).
- R3: A bitmap write while the unit is locked leaves the register unchanged, and the register still reads back its value.
- R4: The bit for trace ID i is bit i%32 of the word at base+(i/32)*4. The base is 0xF8 for sink 0 and 0x108 for sink 1, and each sink owns four words.
- R5: A write to one bitmap word changes only that word. All other words keep their values.
- R6: Reads of unmapped offsets (for example 0xF4 and 0x118) return zero. Writes there change no bitmap word.
- R7: When a sink's bit for the beat's ID is set, that sink's valid is high and the sink sees the input ID and data. When no sink's bit is set, no sink valid is raised and the input is ready in the same cycle.
- R8: The input ready is low while a sink that wants the beat is not ready. The ready of a sink that does not want the beat has no effect.
- R9: A beat wanted by both sinks raises both valids in the same cycle. After one sink takes the beat, that sink's valid drops and the input stays stalled until the other sink takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (combinational) |
| tin_valid | input | 1 | Input beat valid |
| tin_ready | output | 1 | Input beat consumed |
| tin_id | input | 7 | Input trace ID |
| tin_data | input | 32 | Input payload |
| snk_valid | output | 2 | Per-sink valid |
| snk_ready | input | 2 | Per-sink ready |
| snk_id | output | 7 | Trace ID presented to the sinks |
| snk_data | output | 32 | Payload presented to the sinks |

## Verification
The bench builds the block with its default parameters:
- a 7-bit ID, giving four bitmap words per sink;
- a 32-bit payload;
- the sink bases at 0xF8 and 0x108.

These defaults bring the extreme IDs 0 and 127 within reach, along with the word just below sink 0 and the word just above sink 1. The two-sink defaults also allow a beat to be wanted by both sinks, so the staggered acceptance sequence can be driven.

// File: rtl/trace_id_filter.sv
module trace_id_filter #(
  parameter int ID_W   = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SINK0_BASE = 12'h0F8,
  parameter logic [ADDR_W-1:0] SINK1_BASE = 12'h108,
  parameter logic [ADDR_W-1:0] KEY_OFF    = 12'hFB0,
  parameter logic [ADDR_W-1:0] STAT_OFF   = 12'hFB4,
  parameter logic [31:0]       UNLOCK_KEY = 32'hC5ACCE55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              tin_valid,
  output logic              tin_ready,
  input  logic [ID_W-1:0]   tin_id,
  input  logic [DATA_W-1:0] tin_data,
  output logic [1:0]        snk_valid,
  input  logic [1:0]        snk_ready,
  output logic [ID_W-1:0]   snk_id,
  output logic [DATA_W-1:0] snk_data
);
  localparam int NWORD = (1 << ID_W) / 32;

  logic [31:0] bmw [2][NWORD];
  logic [2*NWORD*32-1:0] bm_flat;
  logic        locked;
  logic [1:0]  hit, done;
  logic        wr;

  assign wr = psel && penable && pwrite;

  function automatic logic [ADDR_W-1:0] word_addr(int s, int w);
    return (s == 0 ? SINK0_BASE : SINK1_BASE) + ADDR_W'(4 * w);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b1;
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < NWORD; w++) bmw[s][w] <= '0;
    end else if (wr) begin
      if (paddr == KEY_OFF) locked <= (pwdata != UNLOCK_KEY);
      if (!locked)
        for (int s = 0; s < 2; s++)
          for (int w = 0; w < NWORD; w++)
            if (paddr == word_addr(s, w)) bmw[s][w] <= pwdata;
    end
  end

  always_comb begin
    prdata = '0;
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < NWORD; w++) begin
        bm_flat[(s*NWORD+w)*32 +: 32] = bmw[s][w];
        if (paddr == word_addr(s, w)) prdata = bmw[s][w];
      end
    if (paddr == STAT_OFF) prdata = {30'b0, locked, 1'b0};
  end

  for (genvar i = 0; i < 2; i++) begin : g_sink
    assign hit[i]       = bmw[i][tin_id[ID_W-1:5]][tin_id[4:0]];
    assign snk_valid[i] = tin_valid && hit[i] && !done[i];
  end

  assign tin_ready = (!hit[0] || done[0] || snk_ready[0]) &&
                     (!hit[1] || done[1] || snk_ready[1]);
  assign snk_id    = tin_id;
  assign snk_data  = tin_data;

  always_ff @(posedge clk) begin
    if (!rst_n) done <= '0;
    else if (tin_valid && tin_ready) done <= '0;
    else
      for (int i = 0; i < 2; i++)
        if (snk_valid[i] && snk_ready[i]) done[i] <= 1'b1;
  end

  AST_LOCKED_BM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(bm_flat)); // R3
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == KEY_OFF && pwdata == UNLOCK_KEY) |=> !locked); // R2
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == KEY_OFF && pwdata != UNLOCK_KEY) |=> locked); // R2
  AST_STALL_S0: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid[0] && !snk_ready[0]) |-> !tin_ready); // R8
  AST_STALL_S1: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid[1] && !snk_ready[1]) |-> !tin_ready); // R8
  AST_NO_DUP_S0: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid[0] && snk_ready[0] && !tin_ready) |=> !snk_valid[0]); // R9
  AST_NO_DUP_S1: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid[1] && snk_ready[1] && !tin_ready) |=> !snk_valid[1]); // R9
endmodule

// File: tb/trace_id_filter_bench.sv
module trace_id_filter_bench;
  logic        clk = 0, rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        tin_valid = 0, tin_ready;
  logic [6:0]  tin_id = '0, snk_id;
  logic [31:0] tin_data = '0, snk_data;
  logic [1:0]  snk_valid, snk_ready = 2'b11;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  trace_id_filter u_trace_id_filter (.*);

  // {req(4), is_read(1), addr(12), wdata(32), expected(32)}
  localparam int N = 22;
  localparam logic [80:0] VEC [N] = '{
    {4'd2, 1'b0, 12'hFB0, 32'hC5ACCE55, 32'h0},        // R2 unlock
    {4'd2, 1'b1, 12'hFB4, 32'h0,        32'h0},
    {4'd4, 1'b0, 12'h0F8, 32'h00000020, 32'h0},        // R4 ID5 sink0
    {4'd4, 1'b1, 12'h0F8, 32'h0,        32'h00000020},
    {4'd4, 1'b0, 12'h104, 32'h80000000, 32'h0},        // R4 ID127 sink0
    {4'd4, 1'b1, 12'h104, 32'h0,        32'h80000000},
    {4'd4, 1'b0, 12'h108, 32'h00000001, 32'h0},        // R4 ID0 sink1
    {4'd4, 1'b1, 12'h108, 32'h0,        32'h00000001},
    {4'd5, 1'b1, 12'h0F8, 32'h0,        32'h00000020}, // R5
    {4'd5, 1'b1, 12'h0FC, 32'h0,        32'h0},
    {4'd6, 1'b0, 12'h118, 32'hFFFFFFFF, 32'h0},        // R6
    {4'd6, 1'b1, 12'h118, 32'h0,        32'h0},
    {4'd6, 1'b1, 12'h114, 32'h0,        32'h0},
    {4'd6, 1'b0, 12'h0F4, 32'hFFFFFFFF, 32'h0},
    {4'd6, 1'b1, 12'h0F4, 32'h0,        32'h0},
    {4'd6, 1'b1, 12'h0F8, 32'h0,        32'h00000020},
    {4'd2, 1'b0, 12'hFB0, 32'h12345678, 32'h0},        // R2 relock
    {4'd2, 1'b1, 12'hFB4, 32'h0,        32'h00000002},
    {4'd3, 1'b0, 12'h0F8, 32'hFFFFFFFF, 32'h0},        // R3
    {4'd3, 1'b1, 12'h0F8, 32'h0,        32'h00000020},
    {4'd3, 1'b0, 12'h10C, 32'h0000FFFF, 32'h0},
    {4'd3, 1'b1, 12'h10C, 32'h0,        32'h0}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    #2 d = prdata;
    psel = 0;
  endtask

  task automatic beat(logic [6:0] id, logic [31:0] d, logic [1:0] rdy);
    @(negedge clk); tin_valid = 1; tin_id = id; tin_data = d; snk_ready = rdy;
    #2;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    reg_rd(12'hFB4, r); check("R1 lock status", r, 32'h2);
    for (int w = 0; w < 8; w++) begin
      reg_rd(12'h0F8 + 12'(4 * w), r); check("R1 bitmap zero", r, 32'h0);
    end
    beat(7'd5, 32'hAAAA0001, 2'b11);
    check("R1 no sink valid", {30'b0, snk_valid}, 32'h0);
    check("R1 input ready", {31'b0, tin_ready}, 32'h1);
    @(negedge clk); tin_valid = 0;

    for (int k = 0; k < N; k++) begin
      if (VEC[k][76]) begin
        reg_rd(VEC[k][75:64], r);
        check($sformatf("R%0d table entry %0d", VEC[k][80:77], k), r, VEC[k][31:0]);
      end else reg_wr(VEC[k][75:64], VEC[k][63:32]);
    end

    // R7 forwarding and dropping
    beat(7'd5, 32'h1234ABCD, 2'b11);
    check("R7 sink0 only", {30'b0, snk_valid}, 32'h1);
    check("R7 id", {25'b0, snk_id}, 32'd5);
    check("R7 data", snk_data, 32'h1234ABCD);
    beat(7'd127, 32'h0, 2'b11);
    check("R7 id127 sink0", {30'b0, snk_valid}, 32'h1);
    beat(7'd0, 32'h0, 2'b11);
    check("R7 id0 sink1", {30'b0, snk_valid}, 32'h2);
    beat(7'd6, 32'h0, 2'b00);
    check("R7 dropped valid", {30'b0, snk_valid}, 32'h0);
    check("R7 dropped ready", {31'b0, tin_ready}, 32'h1);
    // R8 stall
    beat(7'd5, 32'h55, 2'b10);
    check("R8 stall", {31'b0, tin_ready}, 32'h0);
    beat(7'd0, 32'h66, 2'b01);
    check("R8 stall sink1", {31'b0, tin_ready}, 32'h0);
    beat(7'd0, 32'h66, 2'b10);
    check("R8 other ready ignored", {31'b0, tin_ready}, 32'h1);
    @(negedge clk); tin_valid = 0;

    // R9 dual acceptance
    reg_wr(12'hFB0, 32'hC5ACCE55);
    reg_wr(12'h108, 32'h00000021);
    reg_wr(12'hFB0, 32'h0);
    beat(7'd5, 32'hBEEF, 2'b01);
    check("R9 both valid", {30'b0, snk_valid}, 32'h3);
    check("R9 stalled", {31'b0, tin_ready}, 32'h0);
    @(negedge clk); #2;
    check("R9 sink0 done", {30'b0, snk_valid}, 32'h2);
    check("R9 still stalled", {31'b0, tin_ready}, 32'h0);
    snk_ready = 2'b11; #1;
    check("R9 retire", {31'b0, tin_ready}, 32'h1);
    check("R9 sink0 no dup", {30'b0, snk_valid}, 32'h2);
    @(negedge clk); tin_valid = 0;
    beat(7'd5, 32'hC0DE, 2'b11);
    check("R9 next beat both", {30'b0, snk_valid}, 32'h3);
    @(negedge clk); tin_valid = 0;
    finish_run();
  end
endmodule